// File: doc/BRIEF.md
# Clock-Sampling Phase Training Controller

This controller finds a good sampling phase for an adjustable clock-phase shifter. A flip-flop samples the received clock using the shifted clock, and the controller reads that flip-flop's value. The controller moves the shifter one unit at a time. Each move is a one-cycle request with a direction, and the controller waits for a one-cycle completion pulse before it does anything else. While it steps, it tracks the shifter position in a signed counter. It records the count where the sampled value first becomes 1 (the rising position). It then records the count of the second transition (the closing position). In double-rate mode the second transition is the sample returning to 0. In single-rate mode it is the next rise, found after a fall.

The controller then computes a target: the closing position minus the rising position, plus a signed skew constant. A full period is 256 steps, so a skew of 64 means a quarter period. The controller steps the shifter to the target and asserts a lock-out flag. After that it leaves the phase alone. The distance between the two positions is also presented as a duty-cycle reading, where 128 means a half period. The controller raises an error flag and halts if the search reaches the top of the range without finding both transitions, or if the target lies outside the range.

Top module: `phase_trainer`

## Requirements
- R1: While the controller waits for lock, its internal step count is zero, so phase_count reads the start of the selected range. No step_en is issued until shifter_locked has been sampled high.
- R2: Each step request is step_en high for exactly one clock. step_up high means increment and low means decrement.
- R3: After a request, no new request is issued and no decision is taken until step_done pulses. phase_count moves by exactly one on that pulse. A step_done with no request outstanding leaves phase_count unchanged.
- R4: In the rising search, the controller increments while sample is 0. The count at which sample is first seen as 1 becomes the rising position.
- R5: With sdr_mode low, the controller keeps incrementing until sample reads 0 again. That count becomes the closing position.
- R6: The target is the closing position minus the rising position plus skew_k, where 256 steps make one period. The controller steps toward the target: down if the count is above it, up if below.
- R7: When the count equals the target, trained goes high. After that no step_en is issued and phase_count stays fixed until reset.
- R8: range_full high makes the range start at -255. range_full low makes it start at 0. The upper limit is +255 in both cases.
- R9: With sdr_mode high, after the rising position the controller increments until sample reads 0. It then keeps incrementing until sample reads 1 again, and that count becomes the closing position.
- R10: If the count reaches +255 while the awaited transition is still missing, train_err goes high and stepping stops for good.
- R11: duty_width holds the closing position minus the rising position from the moment the closing position is captured.
- R12: A transition seen at count +255 counts as found and does not cause an error.
- R13: A target below the range start or above +255 raises train_err without any move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| range_full | input | 1 | 1: range starts at -255; 0: range starts at 0 |
| sdr_mode | input | 1 | 1: second transition is a second rise; 0: a fall |
| skew_k | input | CW | Signed skew constant added to the target |
| shifter_locked | input | 1 | Shifter reports a stable output |
| sample | input | 1 | Received clock as sampled by the shifted clock |
| step_done | input | 1 | One-cycle pulse: the requested step has completed |
| step_en | output | 1 | One-cycle step request |
| step_up | output | 1 | Step direction, 1 means increment |
| phase_count | output | CW | Signed current shifter position |
| duty_width | output | CW | Signed closing position minus rising position |
| trained | output | 1 | Lock-out: training is finished |
| train_err | output | 1 | Training aborted |

## Verification
A transition and the range limit can occur on the same count. The step completion that carries the count to +255 can also be the one at which the awaited edge appears. To provoke this, the shifter model places the second rising edge exactly at +255 in full-range single-rate mode, with a skew chosen so that the target is that same count. The outcome is judged correct only if the edge wins: train_err stays low, duty_width reads 455, trained rises with no return steps, and both the model and the controller report position 255.

// File: rtl/pt_pkg.sv
package pt_pkg;
    typedef enum logic [2:0] {
        ST_WAIT,
        ST_RISE,
        ST_FALL,
        ST_RISE2,
        ST_MOVE,
        ST_DONE,
        ST_ERR
    } pt_state_e;
endpackage

// File: rtl/pt_range_base.sv
module pt_range_base #(
    parameter int CW   = 10,
    parameter int SPAN = 255
) (
    input  logic                 full,
    output logic signed [CW-1:0] base
);
    localparam logic signed [CW-1:0] FULL_START = -CW'(SPAN);
    localparam logic signed [CW-1:0] HALF_START = '0;

    always_comb base = full ? FULL_START : HALF_START;
endmodule

// File: rtl/pt_target_calc.sv
module pt_target_calc #(
    parameter int CW   = 10,
    parameter int SPAN = 255
) (
    input  logic signed [CW-1:0] ps0,
    input  logic signed [CW-1:0] phase,
    input  logic signed [CW-1:0] duty_q,
    input  logic signed [CW-1:0] skew,
    input  logic signed [CW-1:0] base,
    output logic signed [CW-1:0] duty_now,
    output logic signed [CW:0]   target,
    output logic                 target_ok
);
    localparam logic signed [CW:0] TOP = (CW+1)'(SPAN);

    logic signed [CW:0] base_x;

    always_comb begin
        duty_now  = phase - ps0;
        target    = {duty_q[CW-1], duty_q} + {skew[CW-1], skew};
        base_x    = {base[CW-1], base};
        target_ok = (target >= base_x) && (target <= TOP);
    end
endmodule

// File: rtl/phase_trainer.sv
module phase_trainer
    import pt_pkg::*;
#(
    parameter int CW   = 10,
    parameter int SPAN = 255
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 range_full,
    input  logic                 sdr_mode,
    input  logic signed [CW-1:0] skew_k,
    input  logic                 shifter_locked,
    input  logic                 sample,
    input  logic                 step_done,
    output logic                 step_en,
    output logic                 step_up,
    output logic signed [CW-1:0] phase_count,
    output logic signed [CW-1:0] duty_width,
    output logic                 trained,
    output logic                 train_err
);
    localparam logic signed [CW-1:0] LIMIT = CW'(SPAN);
    localparam logic signed [CW-1:0] ONE   = CW'(1);

    typedef struct packed {
        pt_state_e             st;
        logic                  pend;
        logic                  en;
        logic                  up;
        logic                  full;
        logic signed [CW-1:0]  steps;
        logic signed [CW-1:0]  ps0;
        logic signed [CW-1:0]  duty;
    } regs_t;

    regs_t r_d, r_q;

    logic signed [CW-1:0] base;
    logic signed [CW-1:0] phase;
    logic signed [CW:0]   phase_x;
    logic signed [CW-1:0] duty_now;
    logic signed [CW:0]   target;
    logic                 target_ok;

    pt_range_base #(.CW(CW), .SPAN(SPAN)) u_base (
        .full (r_q.full),
        .base (base)
    );

    always_comb begin
        phase   = r_q.steps + base;
        phase_x = {phase[CW-1], phase};
    end

    pt_target_calc #(.CW(CW), .SPAN(SPAN)) u_calc (
        .ps0       (r_q.ps0),
        .phase     (phase),
        .duty_q    (r_q.duty),
        .skew      (skew_k),
        .base      (base),
        .duty_now  (duty_now),
        .target    (target),
        .target_ok (target_ok)
    );

    always_comb begin
        r_d    = r_q;
        r_d.en = 1'b0;
        if (r_q.pend) begin
            if (step_done) begin
                r_d.pend  = 1'b0;
                r_d.steps = r_q.up ? r_q.steps + ONE : r_q.steps - ONE;
            end
        end else begin
            unique case (r_q.st)
                ST_WAIT: begin
                    r_d.full = range_full;
                    if (shifter_locked) begin
                        r_d.en = 1'b1; r_d.up = 1'b1; r_d.pend = 1'b1;
                        r_d.st = ST_RISE;
                    end
                end
                ST_RISE: begin
                    if (sample) begin
                        r_d.ps0 = phase;
                        r_d.st  = ST_FALL;
                    end else if (phase == LIMIT) begin
                        r_d.st = ST_ERR;
                    end else begin
                        r_d.en = 1'b1; r_d.up = 1'b1; r_d.pend = 1'b1;
                    end
                end
                ST_FALL: begin
                    if (!sample) begin
                        if (sdr_mode) begin
                            r_d.st = ST_RISE2;
                        end else begin
                            r_d.duty = duty_now;
                            r_d.st   = ST_MOVE;
                        end
                    end else if (phase == LIMIT) begin
                        r_d.st = ST_ERR;
                    end else begin
                        r_d.en = 1'b1; r_d.up = 1'b1; r_d.pend = 1'b1;
                    end
                end
                ST_RISE2: begin
                    if (sample) begin
                        r_d.duty = duty_now;
                        r_d.st   = ST_MOVE;
                    end else if (phase == LIMIT) begin
                        r_d.st = ST_ERR;
                    end else begin
                        r_d.en = 1'b1; r_d.up = 1'b1; r_d.pend = 1'b1;
                    end
                end
                ST_MOVE: begin
                    if (!target_ok) begin
                        r_d.st = ST_ERR;
                    end else if (phase_x == target) begin
                        r_d.st = ST_DONE;
                    end else begin
                        r_d.en = 1'b1; r_d.up = (target > phase_x); r_d.pend = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_WAIT, pend: 1'b0, en: 1'b0, up: 1'b0, full: 1'b0,
                     steps: '0, ps0: '0, duty: '0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        step_en     = r_q.en;
        step_up     = r_q.up;
        phase_count = phase;
        duty_width  = r_q.duty;
        trained     = (r_q.st == ST_DONE);
        train_err   = (r_q.st == ST_ERR);
    end
endmodule

// File: rtl/pt_checker.sv
module pt_checker #(
    parameter int CW = 10
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 shifter_locked,
    input logic                 step_en,
    input logic                 step_done,
    input logic signed [CW-1:0] phase_count,
    input logic                 trained,
    input logic                 train_err
);
    logic                 lock_seen_q;
    logic                 outstanding_q;
    logic                 moved_q;
    logic signed [CW-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_seen_q   <= 1'b0;
            outstanding_q <= 1'b0;
            moved_q       <= 1'b0;
            prev_q        <= '0;
        end else begin
            lock_seen_q   <= lock_seen_q | shifter_locked;
            outstanding_q <= step_en | (outstanding_q & ~step_done);
            moved_q       <= outstanding_q & step_done;
            prev_q        <= phase_count;
        end
    end

    assert_no_step_before_lock_R1: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |-> lock_seen_q);

    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |=> !step_en);

    assert_wait_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |-> !outstanding_q);

    assert_unit_move_R3: assert property (@(posedge clk) disable iff (!rst_n)
        moved_q |-> ((phase_count == prev_q + CW'(1)) || (phase_count == prev_q - CW'(1))));

    assert_frozen_after_train_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trained |=> (trained && !step_en && $stable(phase_count)));

    assert_halt_on_error_R10: assert property (@(posedge clk) disable iff (!rst_n)
        train_err |=> (train_err && !step_en));

    assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({trained, train_err}));
endmodule

bind phase_trainer pt_checker #(.CW(CW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .shifter_locked (shifter_locked),
    .step_en        (step_en),
    .step_done      (step_done),
    .phase_count    (phase_count),
    .trained        (trained),
    .train_err      (train_err)
);

// File: tb/sim_phase_trainer.sv
module sim_phase_trainer;
    localparam int CW = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic range_full = 1'b0;
    logic sdr_mode = 1'b0;
    logic signed [CW-1:0] skew_k = '0;
    logic shifter_locked = 1'b0;
    logic sample;
    logic step_done;
    logic step_en, step_up, trained, train_err;
    logic signed [CW-1:0] phase_count, duty_width;

    int pos = 0;
    int r1 = 1000, f1 = 1000, r2 = 1000;
    int steps_issued = 0;
    int dbl_pulse = 0;
    logic mdl_done = 1'b0;
    logic stray = 1'b0;
    logic prev_en = 1'b0;
    int n_chk = 0, n_fail = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    assign sample    = ((pos >= r1) && (pos < f1)) || (pos >= r2);
    assign step_done = mdl_done | stray;

    phase_trainer #(.CW(CW), .SPAN(255)) u0 (
        .clk(clk), .rst_n(rst_n), .range_full(range_full), .sdr_mode(sdr_mode),
        .skew_k(skew_k), .shifter_locked(shifter_locked), .sample(sample),
        .step_done(step_done), .step_en(step_en), .step_up(step_up),
        .phase_count(phase_count), .duty_width(duty_width),
        .trained(trained), .train_err(train_err)
    );

    // shifter model: three cycles of latency, then a one-cycle done pulse
    initial begin
        forever begin
            @(negedge clk);
            if (step_en) begin
                automatic int dir = step_up ? 1 : -1;
                steps_issued++;
                repeat (3) @(negedge clk);
                pos += dir;
                mdl_done = 1'b1;
                @(negedge clk);
                mdl_done = 1'b0;
            end
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (step_en && prev_en) dbl_pulse++;
            prev_en = step_en;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic start(input bit full, input bit sdr, input int k,
                         input int a, input int b, input int c);
        rst_n = 1'b0;
        shifter_locked = 1'b0;
        range_full = full;
        sdr_mode = sdr;
        skew_k = CW'(k);
        pos = full ? -255 : 0;
        r1 = a; f1 = b; r2 = c;
        steps_issued = 0;
        dbl_pulse = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        shifter_locked = 1'b1;
    endtask

    task automatic run_to_end();
        int n = 0;
        while (!(trained || train_err) && n < 20000) begin
            @(negedge clk);
            n++;
        end
        repeat (5) @(negedge clk);
    endtask

    task automatic t_reset_wait();
        rst_n = 1'b0; shifter_locked = 1'b0; range_full = 1'b0; pos = 0;
        r1 = 1000; f1 = 1000; r2 = 1000; steps_issued = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (30) @(negedge clk);
        chk("R1 no step before lock", steps_issued, 0);
        chk("R1 half start count", phase_count, 0);
        chk("R1 trained low", trained, 0);
        chk("R1 error low", train_err, 0);
        stray = 1'b1; @(negedge clk); stray = 1'b0;
        repeat (3) @(negedge clk);
        chk("R3 stray done ignored", phase_count, 0);
        range_full = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 R8 full start count", phase_count, -255);
        chk("R1 still no step", steps_issued, 0);
    endtask

    task automatic t_ddr_half();
        start(0, 0, 0, 40, 168, 1000);
        run_to_end();
        chk("R4 R5 R6 trained", trained, 1);
        chk("R11 duty 128", duty_width, 128);
        chk("R6 final count", phase_count, 128);
        chk("R3 model agrees", pos, 128);
        chk("R3 step total", steps_issued, 208);
        chk("R2 single pulses", dbl_pulse, 0);
        repeat (40) @(negedge clk);
        chk("R7 no steps after lock", steps_issued, 208);
        chk("R7 count frozen", phase_count, 128);
    endtask

    task automatic t_full_skew();
        start(1, 0, 64, -100, 30, 1000);
        run_to_end();
        chk("R8 trained", trained, 1);
        chk("R11 duty", duty_width, 130);
        chk("R6 upward move to target", phase_count, 194);
        chk("R8 model", pos, 194);
        chk("R8 step total", steps_issued, 449);
    endtask

    task automatic t_sdr_half();
        start(0, 1, -10, 20, 100, 150);
        run_to_end();
        chk("R9 trained", trained, 1);
        chk("R9 duty two rises", duty_width, 130);
        chk("R9 final count", phase_count, 120);
        chk("R9 step total", steps_issued, 180);
    endtask

    task automatic t_edge_at_limit();
        start(1, 1, -200, -200, 0, 255);
        run_to_end();
        chk("R12 no error", train_err, 0);
        chk("R12 trained", trained, 1);
        chk("R12 duty", duty_width, 455);
        chk("R12 count", phase_count, 255);
        chk("R12 model", pos, 255);
        chk("R12 no return steps", steps_issued, 510);
    endtask

    task automatic t_no_rise();
        start(0, 0, 0, 1000, 1000, 1000);
        run_to_end();
        chk("R10 error on missing rise", train_err, 1);
        chk("R10 trained low", trained, 0);
        chk("R10 stop at limit", phase_count, 255);
        repeat (30) @(negedge clk);
        chk("R10 stepping stopped", steps_issued, 255);
    endtask

    task automatic t_no_fall();
        start(0, 0, 0, 50, 1000, 1000);
        run_to_end();
        chk("R10 error on missing fall", train_err, 1);
        chk("R10 fall limit count", phase_count, 255);
    endtask

    task automatic t_bad_target();
        start(0, 0, -200, 10, 100, 1000);
        run_to_end();
        chk("R13 error", train_err, 1);
        chk("R13 no move", phase_count, 100);
        chk("R13 step total", steps_issued, 100);
    endtask

    initial begin
        while (cyc < 150000) @(negedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset_wait();
        t_ddr_half();
        t_full_skew();
        t_sdr_half();
        t_edge_at_limit();
        t_no_rise();
        t_no_fall();
        t_bad_target();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule